// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Error Status

This block recovers asynchronous serial characters from a receive line. The line is sampled on a tick that runs at sixteen times the bit rate. The tick is an input; the bit-rate generator is outside the block. Each character has one low start bit, 7, 8 or 9 data bits sent least significant bit first, an optional parity bit and one or two high stop bits. Each bit is decided by a majority vote over three samples taken around the middle of the bit.

A completed character goes into a receive buffer with two byte-wide views, a low byte and a high byte. A set of status flags is raised at the same time: buffer-full, parity error, framing error, overrun, and a summary error flag. Software reads are modelled as single-cycle strobes:
- A strobe on the low byte clears buffer-full.
- A strobe on the status clears the error flags.

A control write carries two bits:
- One sets or clears receive enable.
- The other is a self-clearing initialise bit. It clears receive enable, buffer-full and every error flag, and it abandons any character in progress.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, every output is 0: receive enable, the initialise readback, both buffer bytes and all five status flags.
- R2: A character is a low start bit, then data bits least significant first, then an optional parity bit, then one or two stop bits, with 16 ticks per bit. The data length is set by `cfg_len`: 0 gives 7 bits, 1 gives 8 bits, 2 gives 9 bits, and 3 behaves as 8 bits. Each bit takes the majority of the samples at ticks 7, 8 and 9 of its 16-tick period, so a single disturbed sample does not change it.
- R3: A start is abandoned, leaving buffer and flags untouched, when the majority sample of the start bit at mid-bit is high.
- R4: In 7-bit mode, `lo_byte[7]` reads 0 and `hi_byte` reads 0. In 8-bit mode, `hi_byte` reads 0. In 9-bit mode, `hi_byte` is `{7'b0, data[8]}`.
- R5: With `cfg_par_en`=1, a parity error is flagged when the count of ones over the data bits and the parity bit is odd (with `cfg_par_odd`=0) or even (with `cfg_par_odd`=1).
- R6: A framing error is flagged when any stop bit the configuration expects (one, or two when `cfg_two_stop`=1) is sampled low.
- R7: `st_full` rises on each completed character and clears on `rd_lo`.
- R8: A completing character sets `st_ovr` when the buffer still holds an unread character or when any error flag from an earlier character is still set. The new character overwrites the buffer.
- R9: The error flags are sticky until `rd_stat`, which clears all of them. `st_sum` always equals the OR of `st_par`, `st_frm` and `st_ovr`.
- R10: Clearing receive enable during a character lets that character complete. While enable is 0, no new start is accepted.
- R11: A control write with `ctl_init_wd`=1 clears `rx_en`, `st_full` and all error flags, and abandons any character in progress. `rx_init` reads 1 for exactly the one cycle after the write.
- R12: Bit timing advances only on cycles where `tick_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Sampling tick at 16x the bit rate |
| rx_i | input | 1 | Asynchronous serial receive line, idles high |
| cfg_len | input | 2 | Data length: 0 = 7 bits, 1 = 8 bits, 2 = 9 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits expected |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en_wd | input | 1 | Receive enable value written by ctl_wr |
| ctl_init_wd | input | 1 | Initialise bit written by ctl_wr |
| rd_lo | input | 1 | Read strobe for the low receive byte |
| rd_stat | input | 1 | Read strobe for the status flags |
| rx_en | output | 1 | Receive enable readback |
| rx_init | output | 1 | Initialise bit readback, one cycle high |
| lo_byte | output | 8 | Low receive byte |
| hi_byte | output | 8 | High receive byte |
| st_full | output | 1 | Receive buffer full |
| st_par | output | 1 | Parity error flag |
| st_frm | output | 1 | Framing error flag |
| st_ovr | output | 1 | Overrun flag |
| st_sum | output | 1 | Summary error flag |

## Verification
The bound checker watches the following on every cycle:
- The summary flag stays the OR of the three error flags.
- The high byte never carries more than its lowest bit.
- A completion always raises buffer-full, and raises overrun over an unread buffer.
- Read strobes clear their flags on the next cycle.
- The initialise write clears the register state and pulses its readback once.
- A disabled, idle receiver stays idle.
- Nothing in the receiver moves on a cycle without a tick.

Other behaviours depend on whole character sequences, so only the bench scenarios can show them:
- Data assembly and the length modes.
- Parity polarity.
- Stop-bit checking in both stop modes.
- Majority voting against a disturbed sample.
- Rejection of a short start pulse.
- Overrun caused by a stale error flag.
- Completion of a character after enable is dropped mid-character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int CHAR_W = 9;
  localparam int BYTE_W = 8;

  localparam logic [1:0] LEN7 = 2'd0;
  localparam logic [1:0] LEN8 = 2'd1;
  localparam logic [1:0] LEN9 = 2'd2;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP1,
    RX_STOP2
  } rx_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              par_err;
    logic              frm_err;
  } rx_char_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= 1'b1;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote #(
  parameter int OVS  = 16,
  parameter int PH_W = $clog2(OVS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [PH_W-1:0] phase,
  input  logic            rx,
  output logic            bit_val
);

  localparam int MID = OVS / 2;
  localparam logic [PH_W-1:0] PH_A = PH_W'(MID - 1);
  localparam logic [PH_W-1:0] PH_B = PH_W'(MID);

  // two early samples are held; the third is the live line value
  logic [1:0] early;

  always_ff @(posedge clk) begin
    if (rst) begin
      early <= 2'b11;
    end else if (tick) begin
      if (phase == PH_A) early[0] <= rx;
      if (phase == PH_B) early[1] <= rx;
    end
  end

  assign bit_val = (early[0] & early[1]) | (early[0] & rx) | (early[1] & rx);

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int PH_W  = $clog2(OVS),
  parameter int IDX_W = $clog2(CHAR_W)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       abort,
  input  logic       tick,
  input  logic       rx,
  input  logic       rx_en,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  output logic       busy,
  output logic       done,
  output rx_char_t   chr
);

  localparam int MID = OVS / 2;
  localparam logic [PH_W-1:0] PH_SAMP = PH_W'(MID + 1);
  localparam logic [PH_W-1:0] PH_END  = PH_W'(OVS - 1);

  rx_state_e         st;
  logic [PH_W-1:0]   ph;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  last_idx;
  logic [CHAR_W-1:0] dat;
  logic              acc;
  logic              ferr;
  logic              vote;

  uart_rx_vote #(.OVS(OVS), .PH_W(PH_W)) u_vote (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .phase   (ph),
    .rx      (rx),
    .bit_val (vote)
  );

  always_comb begin
    case (cfg_len)
      LEN7:    last_idx = IDX_W'(6);
      LEN9:    last_idx = IDX_W'(8);
      default: last_idx = IDX_W'(7);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      st   <= RX_IDLE;
      ph   <= '0;
      idx  <= '0;
      dat  <= '0;
      acc  <= 1'b0;
      ferr <= 1'b0;
      done <= 1'b0;
      chr  <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (st == RX_IDLE) begin
          if (rx_en && !rx) begin
            st   <= RX_START;
            ph   <= '0;
            idx  <= '0;
            dat  <= '0;
            acc  <= 1'b0;
            ferr <= 1'b0;
          end
        end else begin
          ph <= (ph == PH_END) ? '0 : ph + 1'b1;
          case (st)
            RX_START: begin
              if (ph == PH_SAMP && vote) st <= RX_IDLE;
              else if (ph == PH_END)     st <= RX_DATA;
            end
            RX_DATA: begin
              if (ph == PH_SAMP) begin
                dat[idx] <= vote;
                acc      <= acc ^ vote;
              end
              if (ph == PH_END) begin
                if (idx == last_idx) st <= cfg_par_en ? RX_PAR : RX_STOP1;
                else                 idx <= idx + 1'b1;
              end
            end
            RX_PAR: begin
              if (ph == PH_SAMP) acc <= acc ^ vote;
              if (ph == PH_END)  st  <= RX_STOP1;
            end
            RX_STOP1: begin
              if (ph == PH_SAMP) begin
                if (cfg_two_stop) begin
                  ferr <= ferr | ~vote;
                end else begin
                  st          <= RX_IDLE;
                  done        <= 1'b1;
                  chr.data    <= dat;
                  chr.par_err <= cfg_par_en & (acc ^ cfg_par_odd);
                  chr.frm_err <= ferr | ~vote;
                end
              end else if (ph == PH_END) begin
                st <= RX_STOP2;
              end
            end
            RX_STOP2: begin
              if (ph == PH_SAMP) begin
                st          <= RX_IDLE;
                done        <= 1'b1;
                chr.data    <= dat;
                chr.par_err <= cfg_par_en & (acc ^ cfg_par_odd);
                chr.frm_err <= ferr | ~vote;
              end
            end
            default: st <= RX_IDLE;
          endcase
        end
      end
    end
  end

  assign busy = (st != RX_IDLE);

endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  rx_char_t          chr,
  input  logic [1:0]        cfg_len,
  input  logic              ctl_wr,
  input  logic              ctl_en_wd,
  input  logic              ctl_init_wd,
  input  logic              rd_lo,
  input  logic              rd_stat,
  output logic              rx_en,
  output logic              rx_init,
  output logic [BYTE_W-1:0] lo_byte,
  output logic [BYTE_W-1:0] hi_byte,
  output logic              st_full,
  output logic              st_par,
  output logic              st_frm,
  output logic              st_ovr,
  output logic              st_sum
);

  logic              init_now;
  logic              ovr_new;
  logic              par_base, frm_base, ovr_base, sum_base;
  logic [BYTE_W-1:0] lo_nx, hi_nx;

  assign init_now = ctl_wr & ctl_init_wd;

  always_comb begin
    // a stale error flag left from an earlier character also counts as overrun
    ovr_new  = (st_full & ~rd_lo) | ((st_par | st_frm | st_ovr) & ~rd_stat);
    par_base = st_par & ~rd_stat;
    frm_base = st_frm & ~rd_stat;
    ovr_base = st_ovr & ~rd_stat;
    sum_base = st_sum & ~rd_stat;
    lo_nx    = chr.data[BYTE_W-1:0];
    if (cfg_len == LEN7) lo_nx[BYTE_W-1] = 1'b0;
    hi_nx    = '0;
    if (cfg_len == LEN9) hi_nx[0] = chr.data[CHAR_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en   <= 1'b0;
      rx_init <= 1'b0;
      lo_byte <= '0;
      hi_byte <= '0;
      st_full <= 1'b0;
      st_par  <= 1'b0;
      st_frm  <= 1'b0;
      st_ovr  <= 1'b0;
      st_sum  <= 1'b0;
    end else begin
      rx_init <= init_now;
      if (ctl_wr) rx_en <= ctl_en_wd & ~ctl_init_wd;
      if (init_now) begin
        st_full <= 1'b0;
        st_par  <= 1'b0;
        st_frm  <= 1'b0;
        st_ovr  <= 1'b0;
        st_sum  <= 1'b0;
      end else if (done) begin
        lo_byte <= lo_nx;
        hi_byte <= hi_nx;
        st_full <= 1'b1;
        st_par  <= par_base | chr.par_err;
        st_frm  <= frm_base | chr.frm_err;
        st_ovr  <= ovr_base | ovr_new;
        st_sum  <= sum_base | chr.par_err | chr.frm_err | ovr_new;
      end else begin
        if (rd_lo) st_full <= 1'b0;
        if (rd_stat) begin
          st_par <= 1'b0;
          st_frm <= 1'b0;
          st_ovr <= 1'b0;
          st_sum <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       rx_i,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  input  logic       ctl_wr,
  input  logic       ctl_en_wd,
  input  logic       ctl_init_wd,
  input  logic       rd_lo,
  input  logic       rd_stat,
  output logic       rx_en,
  output logic       rx_init,
  output logic [7:0] lo_byte,
  output logic [7:0] hi_byte,
  output logic       st_full,
  output logic       st_par,
  output logic       st_frm,
  output logic       st_ovr,
  output logic       st_sum
);

  logic     rx_s;
  logic     frm_busy;
  logic     frm_done;
  logic     frm_abort;
  rx_char_t frm_chr;

  assign frm_abort = ctl_wr & ctl_init_wd;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_i),
    .dout (rx_s)
  );

  uart_rx_framer #(.OVS(OVS)) u_framer (
    .clk          (clk),
    .rst          (rst),
    .abort        (frm_abort),
    .tick         (tick_en),
    .rx           (rx_s),
    .rx_en        (rx_en),
    .cfg_len      (cfg_len),
    .cfg_par_en   (cfg_par_en),
    .cfg_par_odd  (cfg_par_odd),
    .cfg_two_stop (cfg_two_stop),
    .busy         (frm_busy),
    .done         (frm_done),
    .chr          (frm_chr)
  );

  uart_rx_regs u_regs (
    .clk         (clk),
    .rst         (rst),
    .done        (frm_done),
    .chr         (frm_chr),
    .cfg_len     (cfg_len),
    .ctl_wr      (ctl_wr),
    .ctl_en_wd   (ctl_en_wd),
    .ctl_init_wd (ctl_init_wd),
    .rd_lo       (rd_lo),
    .rd_stat     (rd_stat),
    .rx_en       (rx_en),
    .rx_init     (rx_init),
    .lo_byte     (lo_byte),
    .hi_byte     (hi_byte),
    .st_full     (st_full),
    .st_par      (st_par),
    .st_frm      (st_frm),
    .st_ovr      (st_ovr),
    .st_sum      (st_sum)
  );

endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_en,
  input logic       ctl_wr,
  input logic       ctl_init_wd,
  input logic       rd_lo,
  input logic       rd_stat,
  input logic       rx_en,
  input logic       rx_init,
  input logic [7:0] hi_byte,
  input logic       st_full,
  input logic       st_par,
  input logic       st_frm,
  input logic       st_ovr,
  input logic       st_sum,
  input logic       done,
  input logic       busy
);

  logic init_w;
  assign init_w = ctl_wr & ctl_init_wd;

  p_hi_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
    hi_byte <= 8'd1);

  p_done_sets_full_r7: assert property (@(posedge clk) disable iff (rst)
    done && !init_w |=> st_full);

  p_rdlo_clears_r7: assert property (@(posedge clk) disable iff (rst)
    rd_lo && !done && !init_w |=> !st_full);

  p_overrun_r8: assert property (@(posedge clk) disable iff (rst)
    done && st_full && !rd_lo && !init_w |=> st_ovr);

  p_sum_is_or_r9: assert property (@(posedge clk) disable iff (rst)
    st_sum == (st_par | st_frm | st_ovr));

  p_rdstat_clears_r9: assert property (@(posedge clk) disable iff (rst)
    rd_stat && !done && !init_w |=> !st_sum && !st_par && !st_frm && !st_ovr);

  p_disabled_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !rx_en && !busy |=> !busy);

  p_init_clears_r11: assert property (@(posedge clk) disable iff (rst)
    init_w |=> !rx_en && !st_full && !st_sum && !busy && rx_init);

  p_init_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    rx_init && !init_w |=> !rx_init);

  p_no_tick_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !tick_en && !init_w |=> $stable(busy) && !done);

endmodule

bind uart_rx_status uart_rx_status_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick_en     (tick_en),
  .ctl_wr      (ctl_wr),
  .ctl_init_wd (ctl_init_wd),
  .rd_lo       (rd_lo),
  .rd_stat     (rd_stat),
  .rx_en       (rx_en),
  .rx_init     (rx_init),
  .hi_byte     (hi_byte),
  .st_full     (st_full),
  .st_par      (st_par),
  .st_frm      (st_frm),
  .st_ovr      (st_ovr),
  .st_sum      (st_sum),
  .done        (frm_done),
  .busy        (frm_busy)
);

// File: tb/uart_rx_status_tb.sv
`timescale 1ns/1ps
module uart_rx_status_tb;

  localparam int BIT_CYC = 32; // 16 ticks, one tick every second clock

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en;
  logic       rx_i = 1'b1;
  logic [1:0] cfg_len = 2'd1;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       ctl_wr = 1'b0;
  logic       ctl_en_wd = 1'b0;
  logic       ctl_init_wd = 1'b0;
  logic       rd_lo = 1'b0;
  logic       rd_stat = 1'b0;
  logic       rx_en, rx_init, st_full, st_par, st_frm, st_ovr, st_sum;
  logic [7:0] lo_byte, hi_byte;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) tick_en <= 1'b0;
    else     tick_en <= ~tick_en;
  end

  uart_rx_status u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .rx_i(rx_i),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .ctl_wr(ctl_wr), .ctl_en_wd(ctl_en_wd),
    .ctl_init_wd(ctl_init_wd), .rd_lo(rd_lo), .rd_stat(rd_stat),
    .rx_en(rx_en), .rx_init(rx_init), .lo_byte(lo_byte), .hi_byte(hi_byte),
    .st_full(st_full), .st_par(st_par), .st_frm(st_frm), .st_ovr(st_ovr),
    .st_sum(st_sum)
  );

  // reference model state
  bit       m_en, m_init, m_full, m_par, m_frm, m_ovr;
  bit [7:0] m_lo, m_hi;
  bit       busy = 1'b1;
  int       n_cmp = 0;
  int       n_bad = 0;
  int       cyc = 0;
  bit       ended = 1'b0;

  task automatic chk(input string req, input string nm, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, nm, act, exp, $time);
    end
  endtask

  // compared on every clock while no character is on the line
  always @(negedge clk) begin
    if (!rst && !busy && !ended) begin
      chk("R11", "rx_en",   rx_en,   m_en);
      chk("R11", "rx_init", rx_init, m_init);
      chk("R2",  "lo_byte", lo_byte, m_lo);
      chk("R4",  "hi_byte", hi_byte, m_hi);
      chk("R7",  "st_full", st_full, m_full);
      chk("R5",  "st_par",  st_par,  m_par);
      chk("R6",  "st_frm",  st_frm,  m_frm);
      chk("R8",  "st_ovr",  st_ovr,  m_ovr);
      chk("R9",  "st_sum",  st_sum,  m_par | m_frm | m_ovr);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !ended) begin
      ended = 1'b1;
      n_bad++;
      $display("FAIL all requirements: watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic apply_char(input bit [8:0] d, input bit perr, input bit ferr);
    bit ovr_new;
    ovr_new = m_full | m_par | m_frm | m_ovr;
    m_lo = d[7:0];
    if (cfg_len == 2'd0) m_lo[7] = 1'b0;
    m_hi = (cfg_len == 2'd2) ? {7'b0, d[8]} : 8'h00;
    m_full = 1'b1;
    m_par = m_par | perr;
    m_frm = m_frm | ferr;
    m_ovr = m_ovr | ovr_new;
  endtask

  task automatic drive_bit(input bit v, input bit glitch);
    rx_i = v;
    if (glitch) begin
      repeat (18) @(posedge clk);
      #1 rx_i = ~v;
      repeat (2) @(posedge clk);
      #1 rx_i = v;
      repeat (12) @(posedge clk);
    end else begin
      repeat (BIT_CYC) @(posedge clk);
    end
    #1;
  endtask

  task automatic send_frame(input bit [8:0] d, input bit bad_par, input bit bad_s1,
                            input bit bad_s2, input bit glitch, input bit expect_rx);
    int n;
    int ones;
    bit p;
    busy = 1'b1;
    n = (cfg_len == 2'd0) ? 7 : (cfg_len == 2'd2) ? 9 : 8;
    ones = 0;
    for (int i = 0; i < n; i++) ones += d[i];
    p = cfg_par_odd ? ~ones[0] : ones[0];
    p = p ^ bad_par;
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < n; i++) drive_bit(d[i], glitch && (i == 2));
    if (cfg_par_en) drive_bit(p, 1'b0);
    drive_bit(~bad_s1, 1'b0);
    if (cfg_two_stop) drive_bit(~bad_s2, 1'b0);
    rx_i = 1'b1;
    repeat (3 * BIT_CYC) @(posedge clk);
    #1;
    if (expect_rx) apply_char(d, bad_par & cfg_par_en, bad_s1 | (cfg_two_stop & bad_s2));
    busy = 1'b0;
  endtask

  task automatic write_ctl(input bit en, input bit init);
    ctl_wr = 1'b1; ctl_en_wd = en; ctl_init_wd = init;
    @(posedge clk); #1;
    ctl_wr = 1'b0; ctl_en_wd = 1'b0; ctl_init_wd = 1'b0;
    if (init) begin
      m_en = 1'b0; m_full = 1'b0; m_par = 1'b0; m_frm = 1'b0; m_ovr = 1'b0;
      m_init = 1'b1;
    end else begin
      m_en = en;
    end
    @(posedge clk); #1;
    m_init = 1'b0;
  endtask

  task automatic do_read(input bit lo, input bit stat);
    rd_lo = lo; rd_stat = stat;
    @(posedge clk); #1;
    rd_lo = 1'b0; rd_stat = 1'b0;
    if (lo) m_full = 1'b0;
    if (stat) begin m_par = 1'b0; m_frm = 1'b0; m_ovr = 1'b0; end
    repeat (3) @(posedge clk); #1;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    busy = 1'b0;
    repeat (4) @(posedge clk); #1;               // R1 reset state compared here

    // R2 / R12: 8 data bits, no parity, one stop, tick every other clock
    write_ctl(1'b1, 1'b0);
    send_frame(9'h0A5, 0, 0, 0, 0, 1);
    do_read(1, 0);                               // R7 full clears on low-byte read
    send_frame(9'h03C, 0, 0, 0, 1, 1);           // R2 single disturbed sample ignored
    do_read(1, 0);

    // R8: second character over an unread buffer
    send_frame(9'h011, 0, 0, 0, 0, 1);
    send_frame(9'h022, 0, 0, 0, 0, 1);
    do_read(0, 1);                               // R9 status read clears flags
    do_read(1, 0);

    // R4 / R5: 7 bits, even parity
    cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send_frame(9'h0FF, 0, 0, 0, 0, 1);           // R4 msb of low byte reads 0
    do_read(1, 0);
    send_frame(9'h055, 1, 0, 0, 0, 1);           // R5 parity error
    do_read(1, 0);
    send_frame(9'h02A, 0, 0, 0, 0, 1);           // R8 overrun from stale error flag
    do_read(1, 1);

    // R4 / R5 / R6: 9 bits, odd parity, two stops
    cfg_len = 2'd2; cfg_par_odd = 1'b1; cfg_two_stop = 1'b1;
    send_frame(9'h1A5, 0, 0, 0, 0, 1);
    do_read(1, 0);
    send_frame(9'h0C3, 0, 0, 1, 0, 1);           // R6 second stop low
    do_read(1, 1);
    send_frame(9'h13E, 1, 0, 0, 0, 1);           // R5 odd parity error
    do_read(1, 1);

    // R6: 8N1 with the only stop low
    cfg_len = 2'd1; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
    send_frame(9'h081, 0, 1, 0, 0, 1);
    do_read(1, 1);

    // R3: short start pulse is rejected
    busy = 1'b1;
    rx_i = 1'b0;
    repeat (8) @(posedge clk);
    #1 rx_i = 1'b1;
    repeat (3 * BIT_CYC) @(posedge clk);
    #1 busy = 1'b0;
    repeat (4) @(posedge clk); #1;

    // R10: enable dropped mid-character, character still completes
    fork
      send_frame(9'h05A, 0, 0, 0, 0, 1);
      begin repeat (100) @(posedge clk); #1; write_ctl(1'b0, 1'b0); end
    join
    send_frame(9'h033, 0, 0, 0, 0, 0);           // R10 ignored while disabled
    do_read(1, 0);

    // R11: initialise clears flags and aborts a character in progress
    write_ctl(1'b1, 1'b0);
    send_frame(9'h044, 0, 0, 0, 0, 1);
    send_frame(9'h066, 0, 0, 0, 0, 1);
    fork
      send_frame(9'h077, 0, 0, 0, 0, 0);
      begin repeat (120) @(posedge clk); #1; write_ctl(1'b0, 1'b1); end
    join
    repeat (8) @(posedge clk); #1;

    ended = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule